// File: doc/BRIEF.md
# Prioritised Interrupt Request Front End

This block sits between five interrupt request lines and the instruction sequencer of a small 8-bit core. The sources are one non-maskable line, three maskable lines that each carry a fixed 16-bit service address, and one maskable line with no fixed address. For that last line the block raises an acknowledge strobe, and the requesting device then drives a restart opcode onto the data bus.

In every cycle the block reports whether an interrupt is waiting and may be taken. The core samples requests only at instruction boundaries, so an interrupt is accepted only in a cycle where the core flags a boundary and also asserts its take input. In the cycle after acceptance the block presents either the service address or the acknowledge pulse. A global enable gates all maskable sources. Software sets it and clears it with strobes. Accepting any interrupt clears it, so a service routine has to set it again. Each addressed maskable line also has its own mask bit, loaded through a write strobe.

Top module: `irqFrontEnd`

## Requirements
- R1: After reset the global enable is 0, all three mask bits read 1 (masked), and irqPending, vecValid, extAck and vecAddr are all 0.
- R2: A rising edge on nmiReq makes an interrupt pending from the next cycle. It is accepted whatever the global enable and the mask bits are, and its address is 16'h0024.
- R3: When several sources are eligible, the one accepted is chosen in this order, highest first: nmiReq, vecReq[2], vecReq[1], vecReq[0], extReq.
- R4: The service addresses are 16'h003C for vecReq[2], 16'h0034 for vecReq[1] and 16'h002C for vecReq[0]. Whenever vecValid is 0, vecAddr reads 0.
- R5: Accepting extReq gives a one-cycle pulse on extAck, and vecValid stays 0 in that cycle.
- R6: vecReq and extReq are taken only while the global enable is 1. A pulse on enSet sets the enable and a pulse on enClr clears it. If both pulse in the same cycle, the clear wins.
- R7: Accepting any interrupt makes enableOut 0 in the following cycle, even if enSet pulses in the accepting cycle.
- R8: A pulse on maskWr loads maskIn into the mask. Mask bit i = 1 blocks vecReq[i]. extReq is not affected by the mask.
- R9: vecReq[2] is edge-triggered. A rising edge is latched and stays pending, even while the line is masked or disabled, until that line is accepted. Holding the line high after it has been serviced does not raise it again.
- R10: vecReq[1], vecReq[0] and extReq are level-sensitive. A request that drops before it is accepted leaves nothing pending.
- R11: An interrupt is accepted only in a cycle where boundary, take and irqPending are all 1. vecValid/vecAddr or extAck follow one cycle later, and are 0 in every other cycle.
- R12: nmiReq held high after it has been serviced does not make it pending again. A new rising edge is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiReq | input | 1 | Non-maskable request, rising-edge detected |
| vecReq | input | 3 | Maskable requests with fixed addresses; bit 2 edge-triggered |
| extReq | input | 1 | Maskable request without a fixed address, level-sensitive |
| maskWr | input | 1 | Load strobe for the mask |
| maskIn | input | 3 | New mask value, 1 = masked |
| enSet | input | 1 | Sets the global enable |
| enClr | input | 1 | Clears the global enable |
| boundary | input | 1 | Core is at an instruction boundary |
| take | input | 1 | Core accepts the pending interrupt now |
| irqPending | output | 1 | An eligible interrupt is waiting |
| vecValid | output | 1 | vecAddr holds a service address this cycle |
| vecAddr | output | 16 | Service address of the accepted source |
| extAck | output | 1 | Acknowledge pulse for the unaddressed source |
| enableOut | output | 1 | Current global enable |
| maskOut | output | 3 | Current mask |

## Verification
The bench targets a pulse on the edge-triggered line while that line is masked. A design that latched the pulse only while the line was unmasked would lose the interrupt. The bench also holds the non-maskable line high after service, and a design that treated it as level-sensitive would take it again and again. Accepting an interrupt in the same cycle as an enable-set strobe checks that acceptance wins; a wrong design would leave the enable on and permit nesting. Take strobes away from a boundary, and level requests dropped before acceptance, catch designs that accept too early or remember a request that has gone away.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int NUM_VEC = 3;
  localparam int IDX_W   = $clog2(NUM_VEC);

  typedef struct packed {
    logic             accept;
    logic             takeNmi;
    logic             takeVec;
    logic             takeExt;
    logic [IDX_W-1:0] vecIdx;
    logic             clrEdge;
  } irqStrobe_t;
endpackage

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
(
  input  logic               nmiPend,
  input  logic               edgePend,
  input  logic [NUM_VEC-1:0] vecReq,
  input  logic               extReq,
  input  logic [NUM_VEC-1:0] maskReg,
  input  logic               enReg,
  input  logic               boundary,
  input  logic               take,
  output logic               irqPending,
  output irqStrobe_t         strobe
);
  logic [NUM_VEC-1:0] lineLive;
  logic               found;
  logic [IDX_W-1:0]   idx;
  logic               accept;

  // Top line uses its latched edge; lower lines are level-sensitive.
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_live
    if (i == NUM_VEC - 1) begin : g_edge
      assign lineLive[i] = edgePend & ~maskReg[i] & enReg;
    end else begin : g_level
      assign lineLive[i] = vecReq[i] & ~maskReg[i] & enReg;
    end
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (!found && lineLive[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign irqPending = nmiPend | found | (extReq & enReg);
  assign accept     = boundary & take & irqPending;

  always_comb begin
    strobe         = '0;
    strobe.accept  = accept;
    strobe.takeNmi = accept & nmiPend;
    strobe.takeVec = accept & ~nmiPend & found;
    strobe.takeExt = accept & ~nmiPend & ~found;
    strobe.vecIdx  = idx;
    strobe.clrEdge = accept & ~nmiPend & found & (idx == IDX_W'(NUM_VEC - 1));
  end
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter logic [15:0] VEC_BASE = 16'h0024,
  parameter logic [15:0] VEC_STEP = 16'h0008
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiReq,
  input  logic               edgeReq,
  input  logic               maskWr,
  input  logic [NUM_VEC-1:0] maskIn,
  input  logic               enSet,
  input  logic               enClr,
  input  irqStrobe_t         strobe,
  output logic               nmiPend,
  output logic               edgePend,
  output logic [NUM_VEC-1:0] maskReg,
  output logic               enReg,
  output logic               vecValid,
  output logic [15:0]        vecAddr,
  output logic               extAck
);
  logic        nmiPrev, edgePrev;
  logic        nmiRise, edgeRise;
  logic [15:0] addrNext;

  assign nmiRise  = nmiReq & ~nmiPrev;
  assign edgeRise = edgeReq & ~edgePrev;

  always_comb begin
    addrNext = '0;
    if (strobe.takeNmi)
      addrNext = VEC_BASE;
    else if (strobe.takeVec)
      addrNext = VEC_BASE + VEC_STEP * (16'(strobe.vecIdx) + 16'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev  <= 1'b0;
      edgePrev <= 1'b0;
      nmiPend  <= 1'b0;
      edgePend <= 1'b0;
      maskReg  <= '1;
      enReg    <= 1'b0;
      vecValid <= 1'b0;
      vecAddr  <= '0;
      extAck   <= 1'b0;
    end else begin
      nmiPrev  <= nmiReq;
      edgePrev <= edgeReq;
      nmiPend  <= nmiRise | (nmiPend & ~strobe.takeNmi);
      edgePend <= edgeRise | (edgePend & ~strobe.clrEdge);
      if (maskWr) maskReg <= maskIn;
      if (strobe.accept || enClr) enReg <= 1'b0;
      else if (enSet)             enReg <= 1'b1;
      vecValid <= strobe.takeNmi | strobe.takeVec;
      vecAddr  <= addrNext;
      extAck   <= strobe.takeExt;
    end
  end
endmodule

// File: rtl/irqFrontEnd.sv
module irqFrontEnd
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiReq,
  input  logic [NUM_VEC-1:0] vecReq,
  input  logic               extReq,
  input  logic               maskWr,
  input  logic [NUM_VEC-1:0] maskIn,
  input  logic               enSet,
  input  logic               enClr,
  input  logic               boundary,
  input  logic               take,
  output logic               irqPending,
  output logic               vecValid,
  output logic [15:0]        vecAddr,
  output logic               extAck,
  output logic               enableOut,
  output logic [NUM_VEC-1:0] maskOut
);
  irqStrobe_t strobe;
  logic       nmiPend, edgePend;

  irqControl ctl_i (
    .nmiPend(nmiPend), .edgePend(edgePend), .vecReq(vecReq), .extReq(extReq),
    .maskReg(maskOut), .enReg(enableOut), .boundary(boundary), .take(take),
    .irqPending(irqPending), .strobe(strobe)
  );

  irqDatapath dp_i (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .edgeReq(vecReq[NUM_VEC-1]),
    .maskWr(maskWr), .maskIn(maskIn), .enSet(enSet), .enClr(enClr),
    .strobe(strobe), .nmiPend(nmiPend), .edgePend(edgePend),
    .maskReg(maskOut), .enReg(enableOut), .vecValid(vecValid),
    .vecAddr(vecAddr), .extAck(extAck)
  );
endmodule

// File: rtl/irqFrontEndChk.sv
module irqFrontEndChk
  import irqPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               boundary,
  input logic               take,
  input logic               irqPending,
  input logic               vecValid,
  input logic [15:0]        vecAddr,
  input logic               extAck,
  input logic               enableOut
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !(vecValid && extAck)); // R5

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    extAck |=> !extAck); // R5

  AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && take && irqPending) |=> !enableOut); // R7

  AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !(boundary && take && irqPending) |=> (!vecValid && !extAck)); // R11

  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> (vecAddr == 16'h0000)); // R4

  AST_ADDR_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecAddr[2:0] == 3'b100 && vecAddr >= 16'h0024 && vecAddr <= 16'h003C)); // R4

  AST_MASKABLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && vecAddr != 16'h0024) |-> $past(enableOut)); // R6
endmodule

bind irqFrontEnd irqFrontEndChk chk_i (.*);

// File: tb/irqFrontEnd_tb_top.sv
`timescale 1ns/1ps
module irqFrontEnd_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, nmiReq, extReq, maskWr, enSet, enClr, boundary, take;
  logic [2:0] vecReq, maskIn;
  logic irqPending, vecValid, extAck, enableOut;
  logic [15:0] vecAddr;
  logic [2:0] maskOut;

  irqFrontEnd dut_i (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .vecReq(vecReq), .extReq(extReq),
    .maskWr(maskWr), .maskIn(maskIn), .enSet(enSet), .enClr(enClr),
    .boundary(boundary), .take(take), .irqPending(irqPending),
    .vecValid(vecValid), .vecAddr(vecAddr), .extAck(extAck),
    .enableOut(enableOut), .maskOut(maskOut)
  );

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  // Reference state built from the requirements
  bit m_nmiPrev, m_nmiPend, m_edgePrev, m_edgePend, m_en, m_vecValid, m_extAck;
  bit [2:0] m_mask;
  bit [15:0] m_vecAddr;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit [15:0] addrOf(int kind, int idx);
    if (kind == 1) return 16'h0024;
    if (kind == 2) return (idx == 2) ? 16'h003C : (idx == 1) ? 16'h0034 : 16'h002C;
    return 16'h0000;
  endfunction

  // kind: 0 none, 1 non-maskable, 2 addressed line idx, 3 extReq
  task automatic evalModel(output bit pend, output int kind, output int idx);
    kind = 0; idx = 0;
    if (m_nmiPend) kind = 1;
    else if (m_en && m_edgePend && !m_mask[2]) begin kind = 2; idx = 2; end
    else if (m_en && vecReq[1] && !m_mask[1]) begin kind = 2; idx = 1; end
    else if (m_en && vecReq[0] && !m_mask[0]) begin kind = 2; idx = 0; end
    else if (m_en && extReq) kind = 3;
    pend = (kind != 0);
  endtask

  task automatic idle();
    nmiReq = 0; vecReq = 0; extReq = 0; maskWr = 0; maskIn = 0;
    enSet = 0; enClr = 0; boundary = 0; take = 0;
  endtask

  task automatic step();
    bit pend, acc;
    int kind, idx;
    #1;
    evalModel(pend, kind, idx);
    chk("irqPending", irqPending, pend);
    chk("vecValid", vecValid, m_vecValid);
    chk("vecAddr", vecAddr, m_vecAddr);
    chk("extAck", extAck, m_extAck);
    chk("enableOut", enableOut, m_en);
    chk("maskOut", maskOut, m_mask);
    acc = pend && boundary && take;
    m_vecValid = acc && (kind == 1 || kind == 2);
    m_vecAddr  = acc ? addrOf(kind, idx) : 16'h0000;
    m_extAck   = acc && kind == 3;
    m_nmiPend  = (nmiReq && !m_nmiPrev) || (m_nmiPend && !(acc && kind == 1));
    m_nmiPrev  = nmiReq;
    m_edgePend = (vecReq[2] && !m_edgePrev) || (m_edgePend && !(acc && kind == 2 && idx == 2));
    m_edgePrev = vecReq[2];
    if (acc || enClr) m_en = 0; else if (enSet) m_en = 1;
    if (maskWr) m_mask = maskIn;
    @(negedge clk);
    idle_keep_levels();
  endtask

  // strobes last one cycle; request levels persist until changed by the caller
  task automatic idle_keep_levels();
    maskWr = 0; enSet = 0; enClr = 0; boundary = 0; take = 0;
  endtask

  task automatic accept();
    boundary = 1; take = 1; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not end actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rstN = 0;
    m_mask = 3'b111;
    repeat (3) @(negedge clk);
    rstN = 1;

    tag = "R1";
    chk("enableOut", enableOut, 0);
    chk("maskOut", maskOut, 3'b111);
    step();

    tag = "R8";
    maskWr = 1; maskIn = 3'b000; step();
    chk("maskOut", maskOut, 3'b000);

    tag = "R6";
    vecReq[0] = 1; accept();
    chk("vecValid while disabled", vecValid, 0);
    enSet = 1; enClr = 1; step();
    chk("enable after set+clear", enableOut, 0);
    enSet = 1; step();
    accept();
    chk("vecAddr line0", vecAddr, 16'h002C);

    tag = "R7";
    vecReq[0] = 0; enSet = 1; step();
    vecReq[1] = 1; boundary = 1; take = 1; enSet = 1; step();
    chk("enable after accept with set", enableOut, 0);
    chk("vecAddr line1", vecAddr, 16'h0034);

    tag = "R3";
    vecReq = 3'b011; extReq = 1; step();
    vecReq[2] = 1; step();
    enSet = 1; step();
    accept();
    chk("vecAddr line2 first", vecAddr, 16'h003C);
    enSet = 1; step(); accept();
    chk("vecAddr line1 next", vecAddr, 16'h0034);
    vecReq[1] = 0; enSet = 1; step(); accept();
    chk("vecAddr line0 next", vecAddr, 16'h002C);

    tag = "R9";
    vecReq = 3'b100; extReq = 0; enSet = 1; step();
    accept();
    chk("held edge line not re-raised", vecValid, 0);
    vecReq[2] = 0; maskWr = 1; maskIn = 3'b100; step();
    vecReq[2] = 1; step(); vecReq[2] = 0; step(); step();
    maskWr = 1; maskIn = 3'b000; enSet = 1; step();
    accept();
    chk("latched pulse served", vecAddr, 16'h003C);

    tag = "R2";
    nmiReq = 1; step();
    accept();
    chk("non-maskable addr", vecAddr, 16'h0024);
    tag = "R12";
    accept(); accept();
    chk("held nmi no retrigger", vecValid, 0);
    nmiReq = 0; step();

    tag = "R10";
    vecReq[1] = 1; enSet = 1; step();
    vecReq[1] = 0; step();
    accept();
    chk("dropped level", vecValid, 0);

    tag = "R5";
    maskWr = 1; maskIn = 3'b111; extReq = 1; enSet = 1; step();
    accept();
    chk("extAck", extAck, 1);
    chk("vecValid with ack", vecValid, 0);
    extReq = 0; step();

    tag = "R11";
    vecReq[0] = 1; maskWr = 1; maskIn = 3'b000; enSet = 1; step();
    take = 1; step();
    chk("take off boundary", vecValid, 0);
    boundary = 1; step();
    chk("boundary without take", vecValid, 0);
    accept();
    chk("boundary and take", vecValid, 1);
    vecReq = 0; step();

    tag = "R3 R4 R6 R7 R8 R9 R10 random";
    for (int c = 0; c < 6000; c++) begin
      if ($urandom % 40 == 0) nmiReq = ~nmiReq;
      for (int b = 0; b < 3; b++) if ($urandom % 10 == 0) vecReq[b] = ~vecReq[b];
      if ($urandom % 12 == 0) extReq = ~extReq;
      maskWr = ($urandom % 20 == 0);
      maskIn = 3'($urandom);
      enSet = ($urandom % 5 == 0);
      enClr = ($urandom % 25 == 0);
      boundary = $urandom % 2;
      take = ($urandom % 3 != 0);
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule